// File: doc/BRIEF.md
# Three-Level PWM Command Decoder

This block sits between a window comparator on a three-level PWM control pin and the gate-drive logic of one synchronous buck phase. Each clock the comparator presents a 2-bit level code: low, high or mid-window. A high level asks for the high-side switch and a low level for the low-side switch. A mid level that persists for a programmable number of consecutive samples places the phase in an idle state with both switches off. This lets a multiphase controller shed a phase simply by parking its PWM line in the middle of the window.

Brief mid-level excursions, such as those seen while the controller's line slews between rails, are filtered. A mid run shorter than the hold-off keeps the current command. Leaving the idle state needs no filtering: the first valid high or low sample sets the matching command at the next clock edge. The two switch commands are never on together.

Top module: `pwm3_decoder`

## Requirements
- R1: While and directly after reset, `cmd_hs_o`=0, `cmd_ls_o`=0 and `idle_o`=1.
- R2: A sample of code 2'b01 (high) makes `cmd_hs_o`=1, `cmd_ls_o`=0 and `idle_o`=0 from the next clock edge.
- R3: A sample of code 2'b00 (low) makes `cmd_ls_o`=1, `cmd_hs_o`=0 and `idle_o`=0 from the next clock edge.
- R4: A run of fewer than HOLDOFF consecutive mid samples leaves all three outputs unchanged.
- R5: On the clock edge that takes the HOLDOFF-th consecutive mid sample, both commands go to 0 and `idle_o` goes to 1.
- R6: Code 2'b11 behaves exactly like the mid code 2'b10, and the two may be mixed within one mid run.
- R7: From the idle state, the first high or low sample applies its command and clears `idle_o` at the next clock edge.
- R8: `cmd_hs_o` and `cmd_ls_o` are never 1 at the same time.
- R9: Any high or low sample restarts the count of consecutive mid samples from zero.
- R10: Once idle, further mid samples keep both commands at 0 and `idle_o` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| level_i | input | 2 | Comparator level code: 00 low, 01 high, 10 or 11 mid |
| cmd_hs_o | output | 1 | High-side switch on command |
| cmd_ls_o | output | 1 | Low-side switch on command |
| idle_o | output | 1 | Phase is in the tri-state idle state |

## Verification
The hardest situation to reach from the ports is the boundary of the hold-off window. A mid run one sample short of HOLDOFF must leave the command alone, and a run of exactly HOLDOFF must trip it. This must hold whichever mid code is used and whichever command was active before. The bench uses a short hold-off and sweeps every mid-run length from zero to beyond the limit. It covers both prior commands, both mid codes and both exit levels. It also splits two just-short runs with a single valid sample to show that the count does not accumulate across them.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

   // comparator level codes
   localparam logic [1:0] LVL_LOW     = 2'b00;
   localparam logic [1:0] LVL_HIGH    = 2'b01;
   localparam logic [1:0] LVL_MID     = 2'b10;
   localparam logic [1:0] LVL_MID_ALT = 2'b11;

   // phase state held by the command register
   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_HS   = 2'b01,
      PH_LS   = 2'b10
   } phase_t;

   typedef struct packed {
      logic hs;
      logic ls;
   } phase_cmd_t;

   function automatic phase_cmd_t phase_to_cmd(input phase_t ph);
      phase_cmd_t c;
      c.hs = (ph == PH_HS);
      c.ls = (ph == PH_LS);
      return c;
   endfunction

endpackage

// File: rtl/pwm3_level_map.sv
module pwm3_level_map
   import pwm3_pkg::*;
(
   input  logic [1:0] code_i,
   output logic       is_low_o,
   output logic       is_high_o,
   output logic       is_mid_o
);

   always_comb begin
      is_low_o  = 1'b0;
      is_high_o = 1'b0;
      is_mid_o  = 1'b0;
      unique case (code_i)
         LVL_LOW:     is_low_o  = 1'b1;
         LVL_HIGH:    is_high_o = 1'b1;
         LVL_MID,
         LVL_MID_ALT: is_mid_o  = 1'b1;
         default:     is_mid_o  = 1'b1;
      endcase
   end

endmodule

// File: rtl/pwm3_holdoff_timer.sv
module pwm3_holdoff_timer #(
   parameter int HOLDOFF = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mid_i,
   output logic expire_o
);

   generate
      if (HOLDOFF < 1) begin : g_bad_holdoff
         $error("pwm3_holdoff_timer: HOLDOFF must be at least 1");
      end

      if (HOLDOFF == 1) begin : g_direct
         // a single mid sample is enough
         assign expire_o = mid_i;
      end else begin : g_count
         localparam int          CW   = $clog2(HOLDOFF);
         localparam logic [CW-1:0] LAST = CW'(HOLDOFF - 1);

         logic [CW-1:0] run_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (!mid_i) begin
               run_q <= '0;
            end else if (run_q != LAST) begin
               run_q <= run_q + 1'b1;
            end
         end

         // this sample completes HOLDOFF consecutive mid samples
         assign expire_o = mid_i && (run_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/pwm3_cmd_state.sv
module pwm3_cmd_state
   import pwm3_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic is_low_i,
   input  logic is_high_i,
   input  logic expire_i,
   output logic hs_o,
   output logic ls_o,
   output logic idle_o
);

   phase_t     ph_q, ph_d;
   phase_cmd_t cmd;

   always_comb begin
      ph_d = ph_q;
      if (is_high_i)      ph_d = PH_HS;
      else if (is_low_i)  ph_d = PH_LS;
      else if (expire_i)  ph_d = PH_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign cmd    = phase_to_cmd(ph_q);
   assign hs_o   = cmd.hs;
   assign ls_o   = cmd.ls;
   assign idle_o = (ph_q == PH_IDLE);

endmodule

// File: rtl/pwm3_decoder.sv
module pwm3_decoder #(
   parameter int HOLDOFF = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] level_i,
   output logic       cmd_hs_o,
   output logic       cmd_ls_o,
   output logic       idle_o
);

   logic is_low, is_high, is_mid, expire;

   pwm3_level_map u_map (
      .code_i    (level_i),
      .is_low_o  (is_low),
      .is_high_o (is_high),
      .is_mid_o  (is_mid)
   );

   pwm3_holdoff_timer #(.HOLDOFF(HOLDOFF)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .mid_i    (is_mid),
      .expire_o (expire)
   );

   pwm3_cmd_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .is_low_i  (is_low),
      .is_high_i (is_high),
      .expire_i  (expire),
      .hs_o      (cmd_hs_o),
      .ls_o      (cmd_ls_o),
      .idle_o    (idle_o)
   );

endmodule

// File: rtl/pwm3_decoder_chk.sv
module pwm3_decoder_chk #(
   parameter int HOLDOFF = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] level_i,
   input logic       cmd_hs_o,
   input logic       cmd_ls_o,
   input logic       idle_o
);

   localparam int           RW   = $clog2(HOLDOFF + 1);
   localparam logic [RW-1:0] LAST = RW'(HOLDOFF - 1);
   localparam logic [RW-1:0] TOP  = RW'(HOLDOFF);

   // consecutive mid samples seen so far, saturating
   logic [RW-1:0] seen_q;
   logic          mid_s;
   assign mid_s = level_i[1];

   always_ff @(posedge clk) begin
      if (!rst_n)             seen_q <= '0;
      else if (!mid_s)        seen_q <= '0;
      else if (seen_q != TOP) seen_q <= seen_q + 1'b1;
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> idle_o && !cmd_hs_o && !cmd_ls_o);

   p_high_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level_i == 2'b01 |=> cmd_hs_o && !cmd_ls_o && !idle_o);

   p_low_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      level_i == 2'b00 |=> cmd_ls_o && !cmd_hs_o && !idle_o);

   p_short_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mid_s && seen_q < LAST |=> $stable({cmd_hs_o, cmd_ls_o, idle_o}));

   p_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mid_s && seen_q == LAST |=> idle_o && !cmd_hs_o && !cmd_ls_o);

   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_hs_o && cmd_ls_o));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o && mid_s |=> idle_o && !cmd_hs_o && !cmd_ls_o);

endmodule

bind pwm3_decoder pwm3_decoder_chk #(.HOLDOFF(HOLDOFF)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .level_i  (level_i),
   .cmd_hs_o (cmd_hs_o),
   .cmd_ls_o (cmd_ls_o),
   .idle_o   (idle_o)
);

// File: tb/test_pwm3_decoder.sv
`timescale 1ns/1ps
module test_pwm3_decoder;

   localparam int H = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] level = 2'b10;
   logic       hs, ls, idle;

   int checks = 0;
   int fails  = 0;

   // reference state built from the requirements
   logic e_hs = 1'b0, e_ls = 1'b0, e_idle = 1'b1;
   int   run = 0;

   always #2.5 clk = ~clk;

   pwm3_decoder #(.HOLDOFF(H)) i_pwm3_decoder (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (level),
      .cmd_hs_o (hs),
      .cmd_ls_o (ls),
      .idle_o   (idle)
   );

   task automatic check(input string tag);
      checks++;
      if ({hs, ls, idle} !== {e_hs, e_ls, e_idle}) begin
         fails++;
         $display("FAIL %s: hs/ls/idle got %b%b%b expected %b%b%b",
                  tag, hs, ls, idle, e_hs, e_ls, e_idle);
      end
      checks++;
      if (hs && ls) begin
         fails++;
         $display("FAIL R8: hs/ls got 11 expected not both set");
      end
   endtask

   task automatic step(input logic [1:0] code, input string tag);
      level = code;
      @(posedge clk);
      @(negedge clk);
      if (code[1]) begin
         run++;
         if (run >= H) begin
            e_hs = 1'b0; e_ls = 1'b0; e_idle = 1'b1;
         end
      end else begin
         run = 0;
         e_hs = (code == 2'b01);
         e_ls = (code == 2'b00);
         e_idle = 1'b0;
      end
      check(tag);
   endtask

   function automatic string mid_tag(input int r, input logic [1:0] mc);
      if (mc == 2'b11)    return "R6";
      if (r + 1 < H)      return "R4";
      if (r + 1 == H)     return "R5";
      return "R10";
   endfunction

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1");
      rst_n = 1'b1;

      for (int p = 0; p < 2; p++) begin
         for (int m = 2; m < 4; m++) begin
            for (int len = 0; len <= H + 2; len++) begin
               for (int e = 0; e < 2; e++) begin
                  step(2'(p), p == 1 ? "R2" : "R3");
                  for (int k = 0; k < len; k++) begin
                     // mix codes inside the run for the 11 sweep
                     logic [1:0] mc;
                     mc = (m == 3 && k[0]) ? 2'b11 : 2'b10;
                     if (m == 3 && k == 0) mc = 2'b11;
                     step(mc, mid_tag(run, mc));
                  end
                  if (e_idle) step(2'(e), "R7");
                  else        step(2'(e), e == 1 ? "R2" : "R3");
               end
            end
         end
      end

      // split short runs must not accumulate
      step(2'b00, "R3");
      for (int k = 0; k < H - 1; k++) step(2'b10, "R9");
      step(2'b01, "R9");
      for (int k = 0; k < H - 1; k++) step(2'b10, "R9");
      step(2'b11, "R5");
      step(2'b10, "R10");

      // reset from an active command
      step(2'b01, "R2");
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      e_hs = 1'b0; e_ls = 1'b0; e_idle = 1'b1; run = 0;
      check("R1");
      rst_n = 1'b1;
      step(2'b00, "R7");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule